// File: doc/BRIEF.md
# Strided Vector Memory Sequencer

This block is a multi-cycle controller that moves a vector between a word-organised memory and a vector register file. It handles a vector load, a vector store and a configuration move. The configuration move sets one of two small registers: the element stride or the element count. The sequencer takes a 16-bit base value and a 6-bit signed offset. It forms byte addresses and issues one memory request per element. As it goes, it steps a 6-bit element index into the register file.

A command is presented for one cycle while the block is idle. A load or store begins at the base plus the offset, which is sign-extended and doubled. Each later element adds the stride, which is zero-extended and doubled. The 16-bit address wraps. The block stalls on each request until memory signals ready. The sequence stops when the element index reaches the stored count. Completion is signalled by a one-cycle done pulse.

Top module: `vec_mem_seq`

## Requirements
- R1: After reset the block is idle: busy, done, mem_req and vrf_we are 0, and the stride and count registers read 0.
- R2: A command with cmd_op=01 is a configuration move. cmd_sel=000 loads cmd_imm into the stride register. cmd_sel=001 loads cmd_imm into the count register. Any other selector changes neither register. The new value is visible after the accepting edge.
- R3: The first request of a load (cmd_op=10) or store (cmd_op=11) uses address cmd_base + (sign-extended cmd_offset << 1), modulo 2^16.
- R4: Each later request uses the previous address plus (zero-extended stride << 1), modulo 2^16.
- R5: A load or store makes exactly as many memory transfers as the count register holds. vrf_idx is 0 for the first transfer and steps by one per transfer. A count of 0 makes no memory request at all.
- R6: For each load transfer, mem_rdata is written to register cmd_sel at element vrf_idx, in the same cycle that mem_ready is seen.
- R7: A store drives mem_we=1. It drives mem_wdata with element vrf_idx of register cmd_sel, which is read through vrf_rdata.
- R8: While mem_req is high and mem_ready is low, the request, address and write flag stay unchanged into the next cycle.
- R9: done is high for exactly one cycle at the end of every accepted command. busy is high from the cycle after acceptance through that cycle. A command presented while busy is ignored.
- R10: Loads and stores never change the stride or count registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 01 config move, 10 load, 11 store, 00 none |
| cmd_sel | input | 3 | Config selector, or vector register number |
| cmd_base | input | 16 | Base address value |
| cmd_offset | input | 6 | Signed element-zero offset |
| cmd_imm | input | 6 | Unsigned immediate for config move |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_stride | output | 6 | Current stride register |
| cfg_length | output | 6 | Current count register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the request this cycle |
| vrf_sel | output | 3 | Vector register number |
| vrf_idx | output | 6 | Element index |
| vrf_we | output | 1 | Register file element write |
| vrf_wdata | output | 16 | Register file write data |
| vrf_rdata | input | 16 | Register file read data for vrf_sel/vrf_idx |

## Verification
The bench targets several corner cases, each tied to a specific failure.

- A count of zero must produce no request and still pulse done. A design that tests the end only after the first access would make one stray transfer.
- A negative offset would land above the base if the design zero-extended it.
- A base near 0xFFF0 with the largest stride checks the address wrap.
- A zero stride with a full count of 63 checks that a repeated address is handled correctly.
- Variable memory latency exposes an index or address that advances without ready.
- A configuration move issued mid-transfer must not alter the count. A design that accepts commands while busy would truncate or extend the vector.

// File: rtl/vec_mem_seq.sv
module vec_mem_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IW = 6,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_sel,
  input  logic [AW-1:0] cmd_base,
  input  logic [IW-1:0] cmd_offset,
  input  logic [IW-1:0] cmd_imm,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] cfg_stride,
  output logic [IW-1:0] cfg_length,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [RW-1:0] vrf_sel,
  output logic [IW-1:0] vrf_idx,
  output logic          vrf_we,
  output logic [DW-1:0] vrf_wdata,
  input  logic [DW-1:0] vrf_rdata
);
  localparam logic [1:0] OP_CFG = 2'b01;
  localparam logic [RW-1:0] SEL_STRIDE = '0;
  localparam logic [RW-1:0] SEL_LENGTH = RW'(1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [IW-1:0] idx_q, stride_q, len_q;
  logic [RW-1:0] sel_q;
  logic          store_q;

  wire accept  = cmd_valid && (st == S_IDLE) && (cmd_op != 2'b00);
  wire is_vec  = cmd_op[1];
  wire is_cfg  = cmd_op == OP_CFG;
  wire last    = idx_q == len_q;
  wire active  = (st == S_RUN) && !last;
  wire xfer    = active && mem_ready;
  wire idx_clr = accept && is_vec;
  wire idx_inc = xfer;

  wire [AW-1:0] off_b = {{(AW-IW-1){cmd_offset[IW-1]}}, cmd_offset, 1'b0};
  wire [AW-1:0] str_b = {{(AW-IW-1){1'b0}}, stride_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (accept) st <= is_vec ? S_RUN : S_DONE;
        S_RUN:   if (last) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      len_q    <= '0;
    end else if (accept && is_cfg) begin
      if (cmd_sel == SEL_STRIDE) stride_q <= cmd_imm;
      if (cmd_sel == SEL_LENGTH) len_q    <= cmd_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (idx_clr) idx_q <= '0;
    else if (idx_inc) idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sel_q   <= '0;
      store_q <= 1'b0;
    end else if (idx_clr) begin
      addr_q  <= cmd_base + off_b;
      sel_q   <= cmd_sel;
      store_q <= cmd_op[0];
    end else if (xfer) begin
      addr_q  <= addr_q + str_b;
    end
  end

  assign busy       = st != S_IDLE;
  assign done       = st == S_DONE;
  assign cfg_stride = stride_q;
  assign cfg_length = len_q;
  assign mem_req    = active;
  assign mem_we     = active && store_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = vrf_rdata;
  assign vrf_sel    = sel_q;
  assign vrf_idx    = idx_q;
  assign vrf_we     = xfer && !store_q;
  assign vrf_wdata  = mem_rdata;
endmodule

// File: rtl/vec_mem_seq_chk.sv
module vec_mem_seq_chk #(
  parameter int AW = 16,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [IW-1:0] cfg_stride,
  input logic [IW-1:0] cfg_length,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic [IW-1:0] vrf_idx,
  input logic          vrf_we
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_stride) && $stable(cfg_length)); // R10
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R5
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> vrf_idx < cfg_length); // R5
  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> mem_req && mem_ready && !mem_we); // R6
endmodule

bind vec_mem_seq vec_mem_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cfg_stride(cfg_stride), .cfg_length(cfg_length),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .vrf_idx(vrf_idx), .vrf_we(vrf_we)
);

// File: tb/vec_mem_seq_tb.sv
module vec_mem_seq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [2:0]  cmd_sel = 0;
  logic [15:0] cmd_base = 0;
  logic [5:0]  cmd_offset = 0, cmd_imm = 0;
  logic        busy, done, mem_req, mem_we, vrf_we;
  logic [5:0]  cfg_stride, cfg_length, vrf_idx;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, vrf_wdata, vrf_rdata;
  logic [2:0]  vrf_sel;
  logic        mem_ready = 0;

  always #2.5 clk = ~clk;

  vec_mem_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_base(cmd_base), .cmd_offset(cmd_offset),
    .cmd_imm(cmd_imm), .busy(busy), .done(done), .cfg_stride(cfg_stride),
    .cfg_length(cfg_length), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .vrf_sel(vrf_sel), .vrf_idx(vrf_idx),
    .vrf_we(vrf_we), .vrf_wdata(vrf_wdata), .vrf_rdata(vrf_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  idx;
    logic [15:0] addr;
    logic [15:0] data;
  } exp_t;
  exp_t q[$];

  logic [15:0] vrf [0:7][0:63];
  int total = 0, bad = 0, nreq = 0, wait_left = 0;
  bit lat_mode = 0;

  assign mem_rdata = mem_addr ^ 16'hA5C3;
  assign vrf_rdata = vrf[vrf_sel][vrf_idx];

  always @(posedge clk) if (vrf_we) vrf[vrf_sel][vrf_idx] <= vrf_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_left > 0) begin
        mem_ready = 0;
        wait_left--;
      end else begin
        exp_t e;
        mem_ready = 1;
        nreq++;
        wait_left = lat_mode ? nreq % 3 : 0;
        if (q.size() == 0) begin
          chk(0, "R5 extra memory access", mem_addr, 0);
        end else begin
          e = q.pop_front();
          chk(mem_addr == e.addr, e.idx == 0 ? "R3 first address" : "R4 stepped address",
              mem_addr, e.addr);
          chk(vrf_idx == e.idx, "R5 element index", vrf_idx, e.idx);
          chk(mem_we == e.we, "R7 write flag", mem_we, e.we);
          if (e.we) chk(mem_wdata == e.data, "R7 store data", mem_wdata, e.data);
        end
      end
    end else begin
      mem_ready = 0;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [2:0] sel,
                       input logic [15:0] base, input logic [5:0] off, input logic [5:0] imm);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_sel = sel;
    cmd_base = base; cmd_offset = off; cmd_imm = imm;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(input bit poke);
    int n = 0;
    bit poked = 0;
    while (!done && n < 5000) begin
      if (poke && !poked && n == 2) begin
        cmd_valid = 1; cmd_op = 2'b01; cmd_sel = 3'b001; cmd_imm = 6'd2;
        poked = 1;
      end else begin
        cmd_valid = 0;
      end
      @(negedge clk);
      n++;
    end
    cmd_valid = 0;
    chk(done, "R9 done seen (watchdog)", done, 1);
    chk(busy, "R9 busy with done", busy, 1);
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle", {done, busy}, 0);
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [5:0] imm);
    issue(2'b01, sel, 16'h0, 6'h0, imm);
    wait_done(0);
  endtask

  task automatic run_vec(input bit store, input logic [2:0] sel,
                         input logic [15:0] base, input logic [5:0] off, input bit poke);
    logic [15:0] a;
    logic [5:0] len, str;
    len = cfg_length;
    str = cfg_stride;
    a = base + {{9{off[5]}}, off, 1'b0};
    for (int i = 0; i < len; i++) begin
      q.push_back({store, 6'(i), a, store ? vrf[sel][i] : 16'h0});
      a = a + {9'h0, str, 1'b0};
    end
    issue(store ? 2'b11 : 2'b10, sel, base, off, 6'h0);
    wait_done(poke);
    chk(q.size() == 0, "R5 transfer count", q.size(), 0);
    q.delete();
    chk(cfg_stride == str && cfg_length == len, "R10 config unchanged",
        {cfg_stride, cfg_length}, {str, len});
    if (!store) begin
      a = base + {{9{off[5]}}, off, 1'b0};
      for (int i = 0; i < 64; i++) begin
        if (i < len) begin
          chk(vrf[sel][i] == (a ^ 16'hA5C3), "R6 loaded element", vrf[sel][i], a ^ 16'hA5C3);
          a = a + {9'h0, str, 1'b0};
        end else begin
          chk(vrf[sel][i] == 16'hDEAD, "R5 element beyond count untouched", vrf[sel][i], 16'hDEAD);
        end
      end
    end
  endtask

  initial begin
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) vrf[r][i] = 16'hDEAD;
    for (int i = 0; i < 64; i++) vrf[5][i] = 16'(i * 16'h0101 + 16'h3000);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !vrf_we, "R1 idle outputs",
        {busy, done, mem_req, vrf_we}, 0);
    chk(cfg_stride == 0 && cfg_length == 0, "R1 config reset", {cfg_stride, cfg_length}, 0);
    rst_n = 1;
    @(negedge clk);

    cfg(3'b000, 6'd3);
    chk(cfg_stride == 3, "R2 stride move", cfg_stride, 3);
    cfg(3'b001, 6'd5);
    chk(cfg_length == 5, "R2 length move", cfg_length, 5);
    cfg(3'b010, 6'd9);
    chk(cfg_stride == 3 && cfg_length == 5, "R2 other selector ignored",
        {cfg_stride, cfg_length}, {6'd3, 6'd5});

    run_vec(0, 3'd2, 16'h1000, 6'd4, 0);
    lat_mode = 1;
    run_vec(0, 3'd3, 16'h2000, 6'd1, 0);
    run_vec(1, 3'd5, 16'h4000, 6'b111110, 0);

    cfg(3'b001, 6'd0);
    run_vec(0, 3'd4, 16'h1234, 6'd0, 0);
    chk(nreq == 15, "R5 zero count no access", nreq, 15);

    cfg(3'b000, 6'd63);
    cfg(3'b001, 6'd4);
    run_vec(0, 3'd6, 16'hFFF0, 6'd2, 0);

    cfg(3'b000, 6'd0);
    cfg(3'b001, 6'd63);
    run_vec(1, 3'd5, 16'h0800, 6'b100000, 0);

    cfg(3'b000, 6'd1);
    cfg(3'b001, 6'd10);
    run_vec(0, 3'd7, 16'h0100, 6'd0, 1);
    chk(cfg_length == 10, "R9 command while busy ignored", cfg_length, 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL R9 global watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule